// File: doc/BRIEF.md
# Codec verb table loader

This block is a hardware bring-up sequencer for an audio link controller. After a start request it lets the link out of reset, waits a short settle time, and samples which of four codec addresses reported presence. Each present codec gets an identity query through the controller's immediate command port. The returned identity is then looked up in a verb table held in a synchronous ROM, and the verbs of the matching entry are streamed to that codec. After every codec has been visited, a shared list of verbs follows. A done pulse, a sticky error flag, a no-codec flag and a mask of codecs that completed end the run.

Every command uses the same handshake on the controller's two status bits. The block waits for busy to be clear, writes the command word, launches it, and then waits for valid set with busy clear. Each wait is bounded by a count of 1 µs ticks. The table is a run of variable-length entries. The search skips each entry that does not match by using the length field in its header.

States and transitions of the top state machine:
- `S_IDLE` goes to `S_SETTLE` on start.
- `S_SETTLE` goes to `S_CODEC_SEL` when the presence mask is nonzero, or to `S_DONE` when it is zero.
- `S_CODEC_SEL` goes to `S_CMD_GO` for a present codec, or to `S_NEXT_CODEC` for an absent one.
- `S_CMD_GO` always goes to `S_CMD_WAIT`.
- `S_CMD_WAIT` leaves on an accepted command or a timeout. It goes to `S_FIND_HDR` after a query, to `S_FETCH` for the next verb, or to `S_NEXT_CODEC` or `S_DONE`.
- `S_FIND_HDR` goes to `S_FIND_ID`, or to `S_NEXT_CODEC` at the end of the table.
- `S_FIND_ID` always goes to `S_FIND_CNT`.
- `S_FIND_CNT` goes back to `S_FIND_HDR` on a mismatch, to `S_FETCH` on a match, or to `S_NEXT_CODEC` for an empty entry.
- `S_FETCH` always goes to `S_LATCH`, and `S_LATCH` always goes to `S_CMD_GO`.
- `S_NEXT_CODEC` goes to `S_CODEC_SEL` for a lower address, to `S_FETCH` for the shared list, or to `S_DONE`.
- `S_DONE` always goes to `S_IDLE`.

The command port runs its own small machine: `C_IDLE`, `C_READY`, `C_WRITE`, `C_LAUNCH`, `C_VALID`.

Top module: `codec_verb_loader`

## Requirements
- R1: A start pulse in idle raises `link_run_o` (link out of reset) and clears error, no-codec and loaded mask. A start pulse while a run is in progress has no effect on the command sequence.
- R2: The 4-bit presence mask is sampled after SETTLE_TICKS ticks. If it is zero, `link_run_o` returns low, `no_codec_o` is set and done pulses, and no command is written.
- R3: Present codecs are handled in descending address order (3, 2, 1, 0). Absent addresses produce no command.
- R4: The identity query for codec address a is the word with a in bits 31:28 and 0x000F0000 in the remaining bits. The response word that accepts it is taken as that codec's identity.
- R5: For each command, the block waits for busy low, pulses `cmd_write_o` with the word on `cmd_data_o`, and pulses `cmd_launch_o` in the following cycle. The command counts as accepted when valid is 1 and busy is 0.
- R6: Each wait gives up after POLL_LIMIT ticks. A timeout sets `error_o` and abandons the rest of that codec's work, and the codec's loaded bit stays clear.
- R7: A table entry is a 3-word header plus a body. Word 0 of the header is the identity and word 2 is N. The body is 4·N verbs. A mismatch moves the search by 4·N+3 words. Running past TABLE_WORDS means no verbs to load, which is not an error. An entry with N = 0 sends nothing.
- R8: The verbs of a matching entry are sent in ascending ROM order, all 4·N of them.
- R9: The shared list is the COMMON_WORDS words at ROM address TABLE_WORDS upward. It is sent after all codecs, even when a codec failed. A timeout inside it ends the run.
- R10: `done_o` is a single-cycle pulse. Bit a of `loaded_mask_o` is set when codec a answered its query and all of its verbs (possibly none) were accepted. `error_o` stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| tick_us_i | input | 1 | One-cycle pulse every microsecond, paces polling |
| presence_i | input | 4 | Codec presence status bits |
| link_run_o | output | 1 | 1 releases the link controller from reset |
| cmd_data_o | output | 32 | Command word for the immediate command register |
| cmd_write_o | output | 1 | Writes `cmd_data_o` into the command register |
| cmd_launch_o | output | 1 | Sets busy and valid to launch the command |
| cmd_busy_i | input | 1 | Command interface busy bit |
| cmd_valid_i | input | 1 | Command interface response-valid bit |
| resp_i | input | 32 | Immediate response word |
| rom_addr_o | output | ROM_AW | Verb ROM read address |
| rom_data_i | input | 32 | Verb ROM data, one cycle after the address |
| done_o | output | 1 | Run finished pulse |
| error_o | output | 1 | A handshake timed out during this run |
| no_codec_o | output | 1 | Presence mask was zero |
| loaded_mask_o | output | 4 | Codecs that completed their programming |

## Verification
A wrong search pointer or verb counter shows directly on `cmd_data_o`. The next command word written is either a word from the wrong entry or a wrong number of verbs, so it differs from the scoreboard within one command. A broken codec index or phase register shows as a query sent to the wrong address, or as a missing or repeated shared-list word. A broken timeout path shows only after the stall has run POLL_LIMIT ticks: the error flag is then wrong or the remaining verbs are still sent, and the loaded mask read after done is wrong.

// File: rtl/cvl_pkg.sv
package cvl_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETTLE,
        S_CODEC_SEL,
        S_CMD_GO,
        S_CMD_WAIT,
        S_FIND_HDR,
        S_FIND_ID,
        S_FIND_CNT,
        S_FETCH,
        S_LATCH,
        S_NEXT_CODEC,
        S_DONE
    } top_state_t;

    typedef enum logic [1:0] {
        PH_ID,
        PH_VERB,
        PH_COMMON
    } phase_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_READY,
        C_WRITE,
        C_LAUNCH,
        C_VALID
    } port_state_t;

    localparam logic [27:0] QUERY_TAIL = 28'h00F_0000;

    function automatic logic [31:0] id_query(input logic [1:0] addr);
        return {2'b00, addr, QUERY_TAIL};
    endfunction

endpackage

// File: rtl/cvl_tick_counter.sv
module cvl_tick_counter #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick && (cnt_q != CW'(LIMIT)))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CW'(LIMIT));

    // R6: the poll count never runs past its limit
    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/cvl_cmd_port.sv
module cvl_cmd_port
    import cvl_pkg::*;
#(
    parameter int unsigned POLL_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic tick,
    input  logic busy_i,
    input  logic valid_i,
    output logic cmd_write,
    output logic cmd_launch,
    output logic ok,
    output logic tmo
);
    port_state_t st_q, st_d;
    logic        expired;
    logic        waiting;
    logic        accepted;

    assign waiting  = (st_q == C_READY) || (st_q == C_VALID);
    assign accepted = valid_i && !busy_i;

    cvl_tick_counter #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!waiting),
        .tick    (tick),
        .expired (expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= C_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            C_IDLE:   if (go) st_d = C_READY;
            C_READY:  if (!busy_i) st_d = C_WRITE;
                      else if (expired) st_d = C_IDLE;
            C_WRITE:  st_d = C_LAUNCH;
            C_LAUNCH: st_d = C_VALID;
            C_VALID:  if (accepted || expired) st_d = C_IDLE;
            default:  st_d = C_IDLE;
        endcase
    end

    always_comb begin
        cmd_write  = (st_q == C_WRITE);
        cmd_launch = (st_q == C_LAUNCH);
        ok         = (st_q == C_VALID) && accepted;
        tmo        = ((st_q == C_READY) && busy_i && expired) ||
                     ((st_q == C_VALID) && !accepted && expired);
    end

    // R5: launch comes exactly one cycle after the write
    a_r5_launch_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_launch |-> $past(cmd_write));
    // R5: a write only follows a cycle in which busy was seen low
    a_r5_write_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_write |-> !$past(busy_i));
    // R6: success and timeout are exclusive
    a_r6_ok_tmo_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && tmo));

endmodule

// File: rtl/codec_verb_loader.sv
module codec_verb_loader
    import cvl_pkg::*;
#(
    parameter int unsigned TABLE_WORDS  = 64,
    parameter int unsigned COMMON_WORDS = 4,
    parameter int unsigned POLL_LIMIT   = 1000,
    parameter int unsigned SETTLE_TICKS = 4,
    parameter int          ROM_AW       = $clog2(TABLE_WORDS + COMMON_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              tick_us_i,
    input  logic [3:0]        presence_i,
    output logic              link_run_o,
    output logic [31:0]       cmd_data_o,
    output logic              cmd_write_o,
    output logic              cmd_launch_o,
    input  logic              cmd_busy_i,
    input  logic              cmd_valid_i,
    input  logic [31:0]       resp_i,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [31:0]       rom_data_i,
    output logic              done_o,
    output logic              error_o,
    output logic              no_codec_o,
    output logic [3:0]        loaded_mask_o
);
    localparam bit          HAS_COMMON = (COMMON_WORDS > 0);
    localparam logic [31:0] TW         = 32'(TABLE_WORDS);
    localparam logic [31:0] LAST_CW    = 32'(COMMON_WORDS) - 32'd1;

    top_state_t  state_q, state_d;
    phase_t      phase_q;
    logic [1:0]  idx_q;
    logic [3:0]  mask_q;
    logic [31:0] id_q;
    logic [31:0] ptr_q;
    logic        match_q;
    logic [31:0] vptr_q;
    logic [31:0] vleft_q;
    logic [31:0] cidx_q;
    logic [31:0] cmd_q;
    logic        link_q;
    logic        err_q;
    logic        noc_q;
    logic [3:0]  loaded_q;

    logic        cmd_go;
    logic        cmd_ok;
    logic        cmd_tmo;
    logic        settle_done;
    logic        table_end;
    logic        cnt_too_big;
    logic        last_verb;
    logic        last_common;
    logic [31:0] body_words;

    assign table_end   = (ptr_q + 32'd3) > TW;
    assign cnt_too_big = rom_data_i >= TW;
    assign body_words  = {rom_data_i[29:0], 2'b00};
    assign last_verb   = (vleft_q == 32'd1);
    assign last_common = (cidx_q == LAST_CW);

    // ---------------- sub-blocks ----------------
    cvl_tick_counter #(.LIMIT(SETTLE_TICKS)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q != S_SETTLE),
        .tick    (tick_us_i),
        .expired (settle_done)
    );

    cvl_cmd_port #(.POLL_LIMIT(POLL_LIMIT)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (cmd_go),
        .tick       (tick_us_i),
        .busy_i     (cmd_busy_i),
        .valid_i    (cmd_valid_i),
        .cmd_write  (cmd_write_o),
        .cmd_launch (cmd_launch_o),
        .ok         (cmd_ok),
        .tmo        (cmd_tmo)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:
                if (start_i) state_d = S_SETTLE;
            S_SETTLE:
                if (settle_done)
                    state_d = (presence_i[3:0] == 4'd0) ? S_DONE : S_CODEC_SEL;
            S_CODEC_SEL:
                state_d = mask_q[idx_q] ? S_CMD_GO : S_NEXT_CODEC;
            S_CMD_GO:
                state_d = S_CMD_WAIT;
            S_CMD_WAIT:
                if (cmd_ok) begin
                    unique case (phase_q)
                        PH_ID:     state_d = S_FIND_HDR;
                        PH_VERB:   state_d = last_verb ? S_NEXT_CODEC : S_FETCH;
                        PH_COMMON: state_d = last_common ? S_DONE : S_FETCH;
                        default:   state_d = S_DONE;
                    endcase
                end else if (cmd_tmo) begin
                    state_d = (phase_q == PH_COMMON) ? S_DONE : S_NEXT_CODEC;
                end
            S_FIND_HDR:
                state_d = table_end ? S_NEXT_CODEC : S_FIND_ID;
            S_FIND_ID:
                state_d = S_FIND_CNT;
            S_FIND_CNT:
                if (cnt_too_big)                          state_d = S_NEXT_CODEC;
                else if (match_q && rom_data_i == 32'd0)  state_d = S_NEXT_CODEC;
                else if (match_q)                         state_d = S_FETCH;
                else                                      state_d = S_FIND_HDR;
            S_FETCH:
                state_d = S_LATCH;
            S_LATCH:
                state_d = S_CMD_GO;
            S_NEXT_CODEC:
                if (idx_q != 2'd0)   state_d = S_CODEC_SEL;
                else if (HAS_COMMON) state_d = S_FETCH;
                else                 state_d = S_DONE;
            S_DONE:
                state_d = S_IDLE;
            default:
                state_d = S_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= PH_ID;
            idx_q    <= 2'd3;
            mask_q   <= 4'd0;
            id_q     <= '0;
            ptr_q    <= '0;
            match_q  <= 1'b0;
            vptr_q   <= '0;
            vleft_q  <= '0;
            cidx_q   <= '0;
            cmd_q    <= '0;
            link_q   <= 1'b0;
            err_q    <= 1'b0;
            noc_q    <= 1'b0;
            loaded_q <= 4'd0;
        end else begin
            unique case (state_q)
                S_IDLE:
                    if (start_i) begin
                        link_q   <= 1'b1;
                        err_q    <= 1'b0;
                        noc_q    <= 1'b0;
                        loaded_q <= 4'd0;
                        idx_q    <= 2'd3;
                        phase_q  <= PH_ID;
                    end
                S_SETTLE:
                    if (settle_done) begin
                        mask_q <= presence_i;
                        if (presence_i == 4'd0) begin
                            link_q <= 1'b0;
                            noc_q  <= 1'b1;
                        end
                    end
                S_CODEC_SEL:
                    if (mask_q[idx_q]) begin
                        cmd_q   <= id_query(idx_q);
                        phase_q <= PH_ID;
                    end
                S_CMD_WAIT:
                    if (cmd_ok) begin
                        unique case (phase_q)
                            PH_ID: begin
                                id_q  <= resp_i;
                                ptr_q <= '0;
                            end
                            PH_VERB:
                                if (last_verb) loaded_q[idx_q] <= 1'b1;
                                else begin
                                    vptr_q  <= vptr_q + 32'd1;
                                    vleft_q <= vleft_q - 32'd1;
                                end
                            PH_COMMON:
                                cidx_q <= cidx_q + 32'd1;
                            default: ;
                        endcase
                    end else if (cmd_tmo) begin
                        err_q <= 1'b1;
                    end
                S_FIND_HDR:
                    if (table_end) loaded_q[idx_q] <= 1'b1;
                S_FIND_ID:
                    match_q <= (rom_data_i == id_q);
                S_FIND_CNT:
                    if (cnt_too_big || (match_q && rom_data_i == 32'd0)) begin
                        loaded_q[idx_q] <= 1'b1;
                    end else if (match_q) begin
                        vptr_q  <= ptr_q + 32'd3;
                        vleft_q <= body_words;
                        phase_q <= PH_VERB;
                    end else begin
                        ptr_q <= ptr_q + body_words + 32'd3;
                    end
                S_LATCH:
                    cmd_q <= rom_data_i;
                S_NEXT_CODEC:
                    if (idx_q != 2'd0) begin
                        idx_q <= idx_q - 2'd1;
                    end else if (HAS_COMMON) begin
                        phase_q <= PH_COMMON;
                        cidx_q  <= '0;
                    end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        cmd_go        = (state_q == S_CMD_GO);
        done_o        = (state_q == S_DONE);
        link_run_o    = link_q;
        error_o       = err_q;
        no_codec_o    = noc_q;
        loaded_mask_o = loaded_q;
        cmd_data_o    = cmd_q;
        unique case (state_q)
            S_FIND_HDR: rom_addr_o = ROM_AW'(ptr_q);
            S_FIND_ID:  rom_addr_o = ROM_AW'(ptr_q + 32'd2);
            S_FETCH:    rom_addr_o = (phase_q == PH_COMMON) ? ROM_AW'(TW + cidx_q)
                                                            : ROM_AW'(vptr_q);
            default:    rom_addr_o = '0;
        endcase
    end

    // ---------------- assertions ----------------
    // R5: no command is written while the link is held in reset
    a_r5_cmd_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_write_o |-> link_run_o);
    // R10: done lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2: a no-codec result leaves the link in reset with nothing loaded
    a_r2_no_codec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        no_codec_o |-> (!link_run_o && loaded_mask_o == 4'd0));
    // R6: a handshake timeout is flagged in the next cycle
    a_r6_timeout_flags_error: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_tmo |=> error_o);
    // R10: error only clears on a start taken in idle
    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(error_o) |-> $past(start_i));

endmodule

// File: tb/tb_codec_verb_loader.sv
`timescale 1ns/1ps
module tb_codec_verb_loader;

    localparam int TW  = 21;
    localparam int CW  = 2;
    localparam int AW  = $clog2(TW + CW + 1);
    localparam int PL  = 6;
    localparam int ST  = 2;

    localparam logic [31:0] ID_A = 32'h10EC_0262;
    localparam logic [31:0] ID_B = 32'h1106_0397;
    localparam logic [31:0] ID_C = 32'h8086_2805;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          tick_us_i = 1'b0;
    logic [3:0]    presence_i = 4'd0;
    logic          link_run_o;
    logic [31:0]   cmd_data_o;
    logic          cmd_write_o;
    logic          cmd_launch_o;
    logic          busy_m;
    logic          valid_m;
    logic [31:0]   resp_m;
    logic [AW-1:0] rom_addr_o;
    logic [31:0]   rom_data;
    logic          done_o;
    logic          error_o;
    logic          no_codec_o;
    logic [3:0]    loaded_mask_o;

    int checks = 0;
    int errors = 0;
    int stall_at = 0;
    logic [31:0] rom [TW+CW];
    logic [31:0] codec_id [4];
    logic [31:0] expq [$];

    always #10 clk = ~clk;

    codec_verb_loader #(
        .TABLE_WORDS(TW), .COMMON_WORDS(CW), .POLL_LIMIT(PL), .SETTLE_TICKS(ST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_us_i(tick_us_i),
        .presence_i(presence_i), .link_run_o(link_run_o), .cmd_data_o(cmd_data_o),
        .cmd_write_o(cmd_write_o), .cmd_launch_o(cmd_launch_o),
        .cmd_busy_i(busy_m), .cmd_valid_i(valid_m), .resp_i(resp_m),
        .rom_addr_o(rom_addr_o), .rom_data_i(rom_data), .done_o(done_o),
        .error_o(error_o), .no_codec_o(no_codec_o), .loaded_mask_o(loaded_mask_o)
    );

    // microsecond tick every fourth cycle
    int tdiv = 0;
    always @(posedge clk) begin
        tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
        tick_us_i <= (tdiv == 3);
    end

    // synchronous ROM model
    always @(posedge clk)
        rom_data <= (int'(rom_addr_o) < TW + CW) ? rom[rom_addr_o] : 32'hFFFF_FFFF;

    // controller + codec model
    function automatic logic [31:0] respond(input logic [31:0] c);
        if (c[31:30] == 2'b00 && c[27:0] == 28'h00F_0000) return codec_id[c[29:28]];
        return 32'h0;
    endfunction

    logic [31:0] last_cmd;
    int lat_cnt;
    int launch_n;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_m <= 1'b0; valid_m <= 1'b0; resp_m <= '0;
            last_cmd <= '0; lat_cnt <= 0; launch_n <= 0;
        end else begin
            if (cmd_write_o) last_cmd <= cmd_data_o;
            if (cmd_launch_o) begin
                busy_m   <= 1'b1;
                valid_m  <= 1'b0;
                launch_n <= launch_n + 1;
                lat_cnt  <= (launch_n + 1 == stall_at) ? 40 : 3;
            end else if (busy_m) begin
                if (lat_cnt == 0) begin
                    busy_m  <= 1'b0;
                    valid_m <= 1'b1;
                    resp_m  <= respond(last_cmd);
                end else lat_cnt <= lat_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every written command against the expected queue
    always @(negedge clk) begin
        if (rst_n && cmd_write_o) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R8 (order R2 R3 R4 R6 R7 R9): actual %h expected <none>", cmd_data_o);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                if (cmd_data_o !== e) begin
                    errors++;
                    $display("FAIL R8 (order R3 R4 R7 R9): actual %h expected %h", cmd_data_o, e);
                end
            end
        end
    end

    // driver helpers
    task automatic push_query(input int a);
        expq.push_back({2'b00, 2'(a), 28'h00F_0000});
    endtask
    task automatic push_verbs(input int base, input int first, input int count);
        for (int k = 0; k < count; k++) expq.push_back(rom[base + 3 + first + k]);
    endtask
    task automatic push_common();
        for (int k = 0; k < CW; k++) expq.push_back(rom[TW + k]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        chk(seen, req, 32'(seen), 32'd1);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single cycle", 32'(done_o), 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // table: A @0 (N=1), B @7 (N=2), C @18 (N=0), shared list @21
        for (int i = 0; i < TW + CW; i++) rom[i] = 32'h0;
        rom[0] = ID_A; rom[1] = 32'h0; rom[2] = 32'd1;
        for (int k = 0; k < 4; k++) rom[3 + k] = 32'h3A00_0000 + 32'(k);
        rom[7] = ID_B; rom[8] = 32'h0; rom[9] = 32'd2;
        for (int k = 0; k < 8; k++) rom[10 + k] = 32'h3B00_0000 + 32'(k);
        rom[18] = ID_C; rom[19] = 32'h0; rom[20] = 32'd0;
        rom[21] = 32'h7770_0001; rom[22] = 32'h7770_0002;
        for (int i = 0; i < 4; i++) codec_id[i] = 32'hDEAD_0000 + 32'(i);

        do_reset();
        // reset state
        chk(link_run_o == 1'b0, "R1 reset link held", 32'(link_run_o), 32'd0);
        chk(done_o == 1'b0, "R10 reset done", 32'(done_o), 32'd0);
        chk(error_o == 1'b0, "R10 reset error", 32'(error_o), 32'd0);
        chk(loaded_mask_o == 4'd0, "R10 reset mask", 32'(loaded_mask_o), 32'd0);
        chk(cmd_write_o == 1'b0, "R5 reset no write", 32'(cmd_write_o), 32'd0);

        // Test A: codecs 3 and 1; 3 matches B after skipping A, 1 has no entry
        presence_i = 4'b1010;
        codec_id[3] = ID_B;
        codec_id[1] = 32'hDEAD_0001;
        push_query(3); push_verbs(7, 0, 8);
        push_query(1);
        push_common();
        pulse_start();
        chk(link_run_o == 1'b1, "R1 link released", 32'(link_run_o), 32'd1);
        repeat (40) @(negedge clk);
        pulse_start(); // R1: must be ignored mid-run
        wait_done("R10 done test A");
        chk(loaded_mask_o == 4'b1010, "R7 R10 loaded A", 32'(loaded_mask_o), 32'hA);
        chk(error_o == 1'b0, "R7 no error A", 32'(error_o), 32'd0);
        chk(no_codec_o == 1'b0, "R2 codec seen A", 32'(no_codec_o), 32'd0);
        chk(expq.size() == 0, "R8 R9 all sent A", 32'(expq.size()), 32'd0);
        chk(link_run_o == 1'b1, "R1 link stays A", 32'(link_run_o), 32'd1);

        // Test B: no codec present
        do_reset();
        presence_i = 4'b0000;
        pulse_start();
        chk(link_run_o == 1'b1, "R1 link released B", 32'(link_run_o), 32'd1);
        wait_done("R2 done test B");
        chk(link_run_o == 1'b0, "R2 link back in reset", 32'(link_run_o), 32'd0);
        chk(no_codec_o == 1'b1, "R2 no codec flag", 32'(no_codec_o), 32'd1);
        chk(loaded_mask_o == 4'd0, "R2 nothing loaded", 32'(loaded_mask_o), 32'd0);

        // Test C: codec 2 = A stalls on its second verb; codec 0 = C (N=0)
        do_reset();
        presence_i = 4'b0101;
        codec_id[2] = ID_A;
        codec_id[0] = ID_C;
        stall_at = 3;
        push_query(2); push_verbs(0, 0, 2);
        push_query(0);
        push_common();
        pulse_start();
        wait_done("R6 done test C");
        chk(error_o == 1'b1, "R6 timeout error", 32'(error_o), 32'd1);
        chk(loaded_mask_o == 4'b0001, "R6 R7 loaded C", 32'(loaded_mask_o), 32'h1);
        chk(expq.size() == 0, "R6 R9 all sent C", 32'(expq.size()), 32'd0);

        // Test D: codec 3 query stalls; shared list still sent
        do_reset();
        presence_i = 4'b1000;
        codec_id[3] = ID_B;
        stall_at = 1;
        push_query(3);
        push_common();
        pulse_start();
        wait_done("R9 done test D");
        chk(error_o == 1'b1, "R6 query timeout", 32'(error_o), 32'd1);
        chk(loaded_mask_o == 4'd0, "R6 nothing loaded D", 32'(loaded_mask_o), 32'd0);
        chk(expq.size() == 0, "R9 shared list after failure", 32'(expq.size()), 32'd0);

        // R1: a new start clears the sticky error
        stall_at = 0;
        push_query(3); push_verbs(7, 0, 8);
        push_common();
        pulse_start();
        chk(error_o == 1'b0, "R1 start clears error", 32'(error_o), 32'd0);
        wait_done("R10 done rerun");
        chk(loaded_mask_o == 4'b1000, "R10 loaded rerun", 32'(loaded_mask_o), 32'h8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule